// File: doc/BRIEF.md
# I2C Master Command Decoder

This block sits between the software-visible control interface of an I2C master and the bit-level bus engine. Each software write supplies a 7-bit control word and a direction bit. The block decodes the write against the master's current high-level state, which is Idle, Transmitting or Receiving. A write that selects a legal operation becomes a registered command descriptor for the engine. The descriptor says:

- whether to issue a (repeated) START,
- the transfer direction,
- single byte or FIFO-fed burst, with the byte count,
- ACK or NACK on the last received byte,
- whether to finish with STOP, or whether to issue a STOP with no data at all.

The high-level state does not change when software writes. It changes only when the engine reports that the issued command has finished, or when the engine reports an error, which forces Idle. While a command is in flight, further writes are refused and a sticky flag records the refused write. Two combinations in the receive state are reported as illegal, and everything else that is not listed is silently treated as a no-operation.

Top module: `i2cm_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mst_state` is 0 (Idle), and `cmd_valid`, `busy`, `illegal_wr`, `err_stat` and `busy_wr_err` are all low. The state encoding is 0 = Idle, 1 = Transmitting, 2 = Receiving.
- R2: The control word bits are bit0 RUN, bit1 START, bit2 STOP, bit3 ACK, bit4 HS, bit5 QCMD, bit6 BURST. `wr_dir_rx` = 1 means receive. In Idle, a write is accepted only if START is set together with exactly one of RUN or BURST. The target state is Receiving if `wr_dir_rx` is 1, Transmitting if it is 0, and Idle if STOP is set. Every other write in Idle is a no-operation.
- R3: In Receiving, without START and with BURST clear, a write of RUN alone gives a single receive ending in NACK. RUN with ACK gives a single receive with ACK. Both keep the state. RUN with STOP gives a single receive followed by STOP and a return to Idle.
- R4: In Receiving or Transmitting, STOP alone (RUN, START and BURST clear; ACK ignored) gives a descriptor with `cmd_stop` = 1, `cmd_data` = 0 and count 0, and leads to Idle.
- R5: In Receiving, BURST without RUN or START gives a FIFO-fed receive of `wr_count` bytes. ACK selects ACK or NACK on the last byte. With STOP added, the burst is followed by STOP and the master goes to Idle; otherwise the state is kept.
- R6: In Receiving, two writes without START are illegal: RUN+STOP+ACK with BURST clear, and STOP+ACK+BURST with RUN clear. Either one pulses `illegal_wr` for one cycle, issues no command and leaves the state unchanged.
- R7: In Transmitting or Receiving, START with exactly one of RUN or BURST issues a repeated START. The direction comes from `wr_dir_rx`, and ACK is applied only for receive. The target state follows the direction, or is Idle if STOP is set.
- R8: In Transmitting, without START, RUN gives a single transmit and BURST gives a FIFO-fed transmit of `wr_count` bytes, both with ACK ignored. Each keeps the state, or goes to Idle with STOP.
- R9: Any write with HS or QCMD set is a no-operation. So are the unlisted combinations, such as RUN and BURST together. A no-operation produces no descriptor and no illegal pulse, and does not change the state.
- R10: An accepted write raises `cmd_valid` for exactly one cycle, starting the cycle after the write, and sets `busy`. `mst_state` changes only after `eng_done` is sampled while busy.
- R11: A write made while `busy` is high is ignored and sets `busy_wr_err`. The flag stays high until the next accepted write clears it.
- R12: A burst write with `wr_count` = 0 is a no-operation.
- R13: `eng_err` forces `mst_state` to Idle, clears `busy` and sets `err_stat`. While `eng_err` is high, writes are not accepted. `err_stat` is cleared by the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_ctl | input | 7 | Control word (RUN, START, STOP, ACK, HS, QCMD, BURST at bits 0..6) |
| wr_dir_rx | input | 1 | Direction bit, 1 = receive |
| wr_count | input | CNT_W | Burst byte count, sampled on the write |
| eng_done | input | 1 | Engine finished the issued command |
| eng_err | input | 1 | Engine error or arbitration lost |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_start | output | 1 | Issue (repeated) START first |
| cmd_rx | output | 1 | Transfer direction, 1 = receive |
| cmd_burst | output | 1 | FIFO-fed burst transfer |
| cmd_ack | output | 1 | ACK the last received byte (0 = NACK) |
| cmd_stop | output | 1 | Finish with STOP |
| cmd_data | output | 1 | Command moves data bytes |
| cmd_count | output | CNT_W | Bytes to move |
| illegal_wr | output | 1 | One-cycle pulse for an illegal write |
| busy | output | 1 | Command in flight |
| mst_state | output | 2 | Master state (0 Idle, 1 Transmitting, 2 Receiving) |
| err_stat | output | 1 | Engine error seen since the last accepted write |
| busy_wr_err | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The assertions check, on every cycle, the rules that hold regardless of the write:

- the state stays put unless the engine reports completion or an error,
- an engine error always lands in Idle with the error bit set,
- an issued command is always accompanied by busy,
- an illegal pulse never coincides with a command,
- writes made while busy never yield a command,
- HS or QCMD writes never yield anything,
- a burst command never carries a zero count.

The decode table itself can only be shown by the directed scenarios. These cover which descriptor fields each combination produces in each state, which target state follows completion, the two illegal receive combinations, repeated START turning the direction around, and the clearing of the sticky flags.

// File: rtl/i2cm_cmd_pkg.sv
package i2cm_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MTX  = 2'd1,
    ST_MRX  = 2'd2
  } mst_state_e;

  typedef enum logic [1:0] {
    DEC_NOP = 2'd0,
    DEC_GO  = 2'd1,
    DEC_ILL = 2'd2
  } dec_kind_e;

  typedef struct packed {
    logic start;
    logic rx;
    logic burst;
    logic ack;
    logic stop;
    logic data;
  } cmd_desc_t;

  localparam int CTL_RUN   = 0;
  localparam int CTL_START = 1;
  localparam int CTL_STOP  = 2;
  localparam int CTL_ACK   = 3;
  localparam int CTL_HS    = 4;
  localparam int CTL_QCMD  = 5;
  localparam int CTL_BURST = 6;
  localparam int CTL_W     = 7;

endpackage

// File: rtl/i2cm_cmd_table.sv
module i2cm_cmd_table
  import i2cm_cmd_pkg::*;
(
  input  mst_state_e        cur_state,
  input  logic [CTL_W-1:0]  ctl,
  input  logic              dir_rx,
  input  logic              cnt_zero,
  output dec_kind_e         kind,
  output cmd_desc_t         desc,
  output mst_state_e        nxt_state
);

  logic run, start, stop, ack, hs, qcmd, burst;

  assign run   = ctl[CTL_RUN];
  assign start = ctl[CTL_START];
  assign stop  = ctl[CTL_STOP];
  assign ack   = ctl[CTL_ACK];
  assign hs    = ctl[CTL_HS];
  assign qcmd  = ctl[CTL_QCMD];
  assign burst = ctl[CTL_BURST];

  always_comb begin
    kind      = DEC_NOP;
    desc      = '0;
    nxt_state = cur_state;
    if (!(hs || qcmd)) begin
      if (start) begin
        // (repeated) START, legal in every state with exactly one of RUN/BURST
        if (run ^ burst) begin
          kind       = DEC_GO;
          desc.start = 1'b1;
          desc.rx    = dir_rx;
          desc.burst = burst;
          desc.ack   = dir_rx & ack;
          desc.stop  = stop;
          desc.data  = 1'b1;
          nxt_state  = stop ? ST_IDLE : (dir_rx ? ST_MRX : ST_MTX);
        end
      end else if (cur_state == ST_MRX) begin
        if ((run && stop && ack && !burst) || (!run && stop && ack && burst)) begin
          kind = DEC_ILL;
        end else if (run ^ burst) begin
          kind       = DEC_GO;
          desc.rx    = 1'b1;
          desc.burst = burst;
          desc.ack   = ack;
          desc.stop  = stop;
          desc.data  = 1'b1;
          nxt_state  = stop ? ST_IDLE : ST_MRX;
        end else if (!run && !burst && stop) begin
          kind      = DEC_GO;
          desc.stop = 1'b1;
          nxt_state = ST_IDLE;
        end
      end else if (cur_state == ST_MTX) begin
        if (run ^ burst) begin
          kind       = DEC_GO;
          desc.burst = burst;
          desc.stop  = stop;
          desc.data  = 1'b1;
          nxt_state  = stop ? ST_IDLE : ST_MTX;
        end else if (!run && !burst && stop) begin
          kind      = DEC_GO;
          desc.stop = 1'b1;
          nxt_state = ST_IDLE;
        end
      end
      if (kind == DEC_GO && desc.burst && cnt_zero) begin
        kind      = DEC_NOP;
        desc      = '0;
        nxt_state = cur_state;
      end
    end
  end

endmodule

// File: rtl/i2cm_state_trk.sv
module i2cm_state_trk
  import i2cm_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  mst_state_e  accept_nxt,
  input  logic        eng_done,
  input  logic        eng_err,
  output mst_state_e  state_q,
  output logic        busy_q,
  output logic        err_q
);

  mst_state_e pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= ST_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (eng_err) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b1;
    end else begin
      if (busy_q && eng_done) begin
        state_q <= pend_q;
        busy_q  <= 1'b0;
      end
      if (accept) begin
        pend_q <= accept_nxt;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
      end
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!eng_done && !eng_err) |=> $stable(state_q)) else $error("state moved without done");  // R10

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    eng_err |=> (state_q == ST_IDLE && err_q && !busy_q)) else $error("error did not force idle");  // R13

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
    (busy_q && eng_done) |=> !busy_q) else $error("busy held after done");  // R10

endmodule

// File: rtl/i2cm_cmd_decoder.sv
module i2cm_cmd_decoder
  import i2cm_cmd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [6:0]       wr_ctl,
  input  logic             wr_dir_rx,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             cmd_valid,
  output logic             cmd_start,
  output logic             cmd_rx,
  output logic             cmd_burst,
  output logic             cmd_ack,
  output logic             cmd_stop,
  output logic             cmd_data,
  output logic [CNT_W-1:0] cmd_count,
  output logic             illegal_wr,
  output logic             busy,
  output logic [1:0]       mst_state,
  output logic             err_stat,
  output logic             busy_wr_err
);

  localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(1);

  mst_state_e  state_w, nxt_w;
  dec_kind_e   kind_w;
  cmd_desc_t   desc_w, desc_q;
  logic        accept;
  logic        busy_w;

  i2cm_cmd_table u_table (
    .cur_state (state_w),
    .ctl       (wr_ctl),
    .dir_rx    (wr_dir_rx),
    .cnt_zero  (wr_count == '0),
    .kind      (kind_w),
    .desc      (desc_w),
    .nxt_state (nxt_w)
  );

  assign accept = wr_en && !busy_w && !eng_err && (kind_w == DEC_GO);

  i2cm_state_trk u_trk (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .accept_nxt (nxt_w),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .state_q    (state_w),
    .busy_q     (busy_w),
    .err_q      (err_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid   <= 1'b0;
      desc_q      <= '0;
      cmd_count   <= '0;
      illegal_wr  <= 1'b0;
      busy_wr_err <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      illegal_wr <= 1'b0;
      if (wr_en && busy_w) begin
        busy_wr_err <= 1'b1;
      end else if (accept) begin
        cmd_valid   <= 1'b1;
        desc_q      <= desc_w;
        cmd_count   <= desc_w.burst ? wr_count : (desc_w.data ? ONE_BYTE : '0);
        busy_wr_err <= 1'b0;
      end else if (wr_en && !eng_err && kind_w == DEC_ILL) begin
        illegal_wr <= 1'b1;
      end
    end
  end

  assign cmd_start = desc_q.start;
  assign cmd_rx    = desc_q.rx;
  assign cmd_burst = desc_q.burst;
  assign cmd_ack   = desc_q.ack;
  assign cmd_stop  = desc_q.stop;
  assign cmd_data  = desc_q.data;
  assign busy      = busy_w;
  assign mst_state = state_w;

  AST_VALID_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy_w) else $error("command issued without busy");  // R10

  AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_w) |=> (busy_wr_err && !cmd_valid)) else $error("busy write not refused");  // R11

  AST_ILLEGAL_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    illegal_wr |-> (!cmd_valid && !busy_w)) else $error("illegal write started work");  // R6

  AST_HS_QCMD_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_ctl[CTL_HS] || wr_ctl[CTL_QCMD])) |=> (!cmd_valid && !illegal_wr)) else $error("HS/QCMD write not ignored");  // R9

  AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_burst) |-> (cmd_count != '0)) else $error("burst with zero count");  // R12

endmodule

// File: tb/tb_i2cm_cmd_decoder.sv
`timescale 1ns/1ps
module tb_i2cm_cmd_decoder;

  localparam int CNT_W = 8;
  localparam logic [6:0] RUN = 7'h01, START = 7'h02, STOP = 7'h04, ACK = 7'h08,
                         HS = 7'h10, QCMD = 7'h20, BURST = 7'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [6:0] wr_ctl = '0;
  logic wr_dir_rx = 1'b0;
  logic [CNT_W-1:0] wr_count = '0;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic cmd_valid, cmd_start, cmd_rx, cmd_burst, cmd_ack, cmd_stop, cmd_data;
  logic [CNT_W-1:0] cmd_count;
  logic illegal_wr, busy, err_stat, busy_wr_err;
  logic [1:0] mst_state;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  i2cm_cmd_decoder #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_dir_rx(wr_dir_rx),
    .wr_count(wr_count), .eng_done(eng_done), .eng_err(eng_err),
    .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmd_rx(cmd_rx), .cmd_burst(cmd_burst),
    .cmd_ack(cmd_ack), .cmd_stop(cmd_stop), .cmd_data(cmd_data), .cmd_count(cmd_count),
    .illegal_wr(illegal_wr), .busy(busy), .mst_state(mst_state), .err_stat(err_stat),
    .busy_wr_err(busy_wr_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one write; returns at the negedge after the sampling edge
  task automatic wr(input logic [6:0] c, input logic rx, input logic [CNT_W-1:0] n);
    @(negedge clk);
    wr_en = 1'b1; wr_ctl = c; wr_dir_rx = rx; wr_count = n;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_ctl = '0;
  endtask

  task automatic done_pulse();
    eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // accepted write: descriptor {start,rx,burst,ack,stop,data}
  task automatic go(input string tag, input logic [6:0] c, input logic rx, input logic [CNT_W-1:0] n,
                    input logic [5:0] exp_d, input logic [CNT_W-1:0] exp_n, input logic [1:0] exp_st);
    logic [1:0] s0;
    s0 = mst_state;
    wr(c, rx, n);
    chk({tag, " valid"}, cmd_valid, 1);
    chk({tag, " desc"}, {cmd_start, cmd_rx, cmd_burst, cmd_ack, cmd_stop, cmd_data}, exp_d);
    chk({tag, " count"}, cmd_count, exp_n);
    chk({tag, " R10 state held before done"}, mst_state, s0);
    @(negedge clk);
    chk({tag, " R10 single pulse"}, cmd_valid, 0);
    done_pulse();
    chk({tag, " next state"}, mst_state, exp_st);
    chk({tag, " R10 busy released"}, busy, 0);
  endtask

  task automatic nop(input string tag, input logic [6:0] c, input logic rx, input logic [CNT_W-1:0] n);
    logic [1:0] s0;
    s0 = mst_state;
    wr(c, rx, n);
    chk({tag, " no cmd"}, cmd_valid, 0);
    chk({tag, " no illegal"}, illegal_wr, 0);
    chk({tag, " not busy"}, busy, 0);
    @(negedge clk);
    chk({tag, " state kept"}, mst_state, s0);
  endtask

  task automatic ill(input string tag, input logic [6:0] c, input logic [CNT_W-1:0] n);
    logic [1:0] s0;
    s0 = mst_state;
    wr(c, 1'b0, n);
    chk({tag, " illegal pulse"}, illegal_wr, 1);
    chk({tag, " no cmd"}, cmd_valid, 0);
    chk({tag, " not busy"}, busy, 0);
    @(negedge clk);
    chk({tag, " pulse ends"}, illegal_wr, 0);
    chk({tag, " state kept"}, mst_state, s0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 state", mst_state, 0);
    chk("R1 valid", cmd_valid, 0);
    chk("R1 flags", {busy, illegal_wr, err_stat, busy_wr_err}, 0);
  endtask

  task automatic t_idle();
    nop("R2 idle RUN", RUN, 1'b0, 8'd1);
    nop("R2 idle STOP", STOP, 1'b0, 8'd1);
    go("R2 idle start tx", START | RUN, 1'b0, 8'd9, 6'b100001, 8'd1, 2'd1);
  endtask

  task automatic t_mtx();
    go("R8 tx single", RUN | ACK, 1'b0, 8'd7, 6'b000001, 8'd1, 2'd1);
    go("R8 tx burst", BURST, 1'b0, 8'd3, 6'b001001, 8'd3, 2'd1);
    nop("R12 tx burst zero", BURST, 1'b0, 8'd0);
    go("R7 tx->rx restart", START | RUN | ACK, 1'b1, 8'd1, 6'b110101, 8'd1, 2'd2);
  endtask

  task automatic t_mrx();
    go("R3 rx nack", RUN, 1'b0, 8'd1, 6'b010001, 8'd1, 2'd2);
    go("R3 rx ack", RUN | ACK, 1'b0, 8'd1, 6'b010101, 8'd1, 2'd2);
    ill("R6 run stop ack", RUN | STOP | ACK, 8'd1);
    ill("R6 stop ack burst", STOP | ACK | BURST, 8'd4);
    nop("R9 hs", RUN | HS, 1'b0, 8'd1);
    nop("R9 qcmd", BURST | QCMD, 1'b0, 8'd2);
    nop("R9 run+burst", RUN | BURST, 1'b0, 8'd2);
    go("R5 rx burst nack", BURST, 1'b0, 8'd5, 6'b011001, 8'd5, 2'd2);
    go("R5 rx burst ack", BURST | ACK, 1'b0, 8'd2, 6'b011101, 8'd2, 2'd2);
    nop("R12 rx burst zero", BURST | ACK, 1'b0, 8'd0);
    go("R7 rx->tx restart", START | RUN | ACK, 1'b0, 8'd1, 6'b100001, 8'd1, 2'd1);
    go("R7 tx->rx burst restart", START | BURST, 1'b1, 8'd2, 6'b111001, 8'd2, 2'd2);
    go("R5 rx burst stop", BURST | STOP, 1'b0, 8'd4, 6'b011011, 8'd4, 2'd0);
  endtask

  task automatic t_stops();
    go("R2 idle start rx", START | RUN, 1'b1, 8'd1, 6'b110001, 8'd1, 2'd2);
    go("R4 rx stop only", STOP | ACK, 1'b0, 8'd3, 6'b000010, 8'd0, 2'd0);
    go("R2 idle start rx2", START | RUN, 1'b1, 8'd1, 6'b110001, 8'd1, 2'd2);
    go("R3 rx then stop", RUN | STOP, 1'b0, 8'd1, 6'b010011, 8'd1, 2'd0);
    go("R7 start tx stop", START | RUN | STOP, 1'b0, 8'd1, 6'b100011, 8'd1, 2'd0);
    go("R2 idle start tx2", START | RUN, 1'b0, 8'd1, 6'b100001, 8'd1, 2'd1);
    go("R8 tx stop only", STOP, 1'b0, 8'd1, 6'b000010, 8'd0, 2'd0);
  endtask

  task automatic t_busy();
    wr(START | RUN, 1'b0, 8'd1);
    chk("R11 first accepted", cmd_valid, 1);
    wr(RUN, 1'b0, 8'd1);
    chk("R11 busy write no cmd", cmd_valid, 0);
    chk("R11 sticky flag set", busy_wr_err, 1);
    chk("R10 still idle while busy", mst_state, 0);
    @(negedge clk);
    chk("R11 flag sticky", busy_wr_err, 1);
    done_pulse();
    chk("R10 state after done", mst_state, 1);
    wr(RUN | STOP, 1'b0, 8'd1);
    chk("R11 flag cleared by accept", busy_wr_err, 0);
    done_pulse();
    chk("R8 tx stop to idle", mst_state, 0);
  endtask

  task automatic t_err();
    wr(START | RUN, 1'b1, 8'd1);
    chk("R13 cmd accepted", cmd_valid, 1);
    eng_err = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_err = 1'b0;
    chk("R13 idle after error", mst_state, 0);
    chk("R13 err set", err_stat, 1);
    chk("R13 busy cleared", busy, 0);
    wr(START | RUN, 1'b0, 8'd1);
    chk("R13 err cleared on accept", err_stat, 0);
    done_pulse();
    chk("R13 recovered to tx", mst_state, 1);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_mtx();
    t_mrx();
    t_stops();
    t_busy();
    t_err();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule